// File: doc/BRIEF.md
# ADC Power-Up Calibration Sequencer

This block is the host-side master for the serial port of a 12-bit SAR converter that needs an offset calibration after power-up. On the first start request after reset it lowers chip-select and holds it low for a fixed run of serial clocks. During that frame the converter trims its offset, and the data line must read as zero throughout. The block then raises chip-select for an acquisition interval and runs an ordinary sample frame on its own. Every later start request in the idle state runs one more sample frame.

The serial clock half-period is programmable in system clocks. During the calibration frame it is raised to a floor that depends on the supply range: the lower supply range needs a slower clock. Sample frames shift the data line in MSB-first on serial clock rising edges and present a 12-bit word with a one-cycle strobe. The block flags three conditions: calibration completed, a non-zero bit seen during calibration, and calibration not applied because the frame was cut short by an explicit abort.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After a synchronous active-high reset, `csN` is 1, `sclk` is 0, and `calDone`, `calError`, `calNotApplied` and `sampleValid` are 0. No frame starts until `start` is pulsed.
- R2: The first frame after reset is a calibration frame. `csN` stays low for exactly CAL_EDGES (16) `sclk` rising edges, and when it completes `calDone` is set and stays set until reset.
- R3: `sclk` is 0 whenever `csN` is high, so it only toggles inside a frame.
- R4: In the calibration frame every `sclk` high phase lasts max(d, F) system clocks. Here d is `sclkDiv`, with 0 treated as 1. F is CAL_HALF_LO (3) when `lowSupply` is 1 and CAL_HALF_HI (2) when it is 0.
- R5: If `sdo` is 1 at any `sclk` rising edge of the calibration frame, `calError` is set and stays set until reset. If `sdo` reads all zeros, `calError` stays 0.
- R6: `abortReq` during the clocking of the calibration frame ends that frame early. It sets `calNotApplied` and leaves `calDone` at 0, and the sequence then carries on to the sample frame. `abortReq` at any other time has no effect.
- R7: After the calibration frame, `csN` stays high for at least CS_HIGH_CYC + ACQ_CYC (10 + 16) system clocks. The first sample frame then starts without another `start` pulse.
- R8: A sample frame has LEAD_BITS + DATA_BITS (2 + 12) rising edges, with high phases of d clocks. The bits at rising edges 3 to 14 form `sampleData`, MSB first, and the bits at edges 1 and 2 are discarded. `sampleValid` is a one-cycle pulse, raised while `csN` is high.
- R9: After a sample frame, `csN` stays high for at least CS_HIGH_CYC clocks. `start` begins a new sample frame only once that wait has ended; a `start` pulse during a frame or during the wait is ignored.
- R10: A reset in the middle of the sequence returns the block to its power-up state, so the next frame is a calibration frame again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset to the power-up state |
| start | input | 1 | One-cycle request to begin the sequence or another sample frame |
| abortReq | input | 1 | Forces an early end of the calibration frame |
| sclkDiv | input | 8 | Serial clock half-period in system clocks (0 acts as 1) |
| lowSupply | input | 1 | Selects the slower calibration clock floor |
| sdo | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip-select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| calDone | output | 1 | Calibration frame completed with the full clock count |
| calError | output | 1 | A 1 was read during the calibration frame |
| calNotApplied | output | 1 | Calibration frame was aborted before completion |
| sampleValid | output | 1 | One-cycle strobe for a new `sampleData` word |
| sampleData | output | 12 | Last converted word, MSB first from the line |

## Verification
The bench runs the full sequence with a divider below the calibration floor at both supply settings. A design that ignored the floor would show calibration high phases that are too short. In sample frames the converter model drives the two leading bits as 1, so a design that kept them, or dropped the wrong bits, returns a shifted word. An injected 1 on the sixteenth calibration edge catches a frame cut one edge short, and an abort after five edges must yield a five-edge frame with `calDone` still clear. Start pulses during the post-frame wait and in mid-frame must not add frames, and a reset in mid-sample must bring back a calibration frame.

// File: rtl/adc_cal_pkg.sv
`timescale 1ns/1ps
package adc_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_FALL,
    ST_CAL_CLK,
    ST_CAL_HIGH,
    ST_ACQ_WAIT,
    ST_SAMPLE,
    ST_SMP_HIGH,
    ST_DONE
  } seqState_t;

  // Strobes from the sequencer control to the serial datapath
  typedef struct packed {
    logic run;      // clock generator active (frame in progress)
    logic stop;     // frame ends at this edge: park sclk low
    logic calMode;  // calibration frame: clock floor and edge count
    logic waitLoad; // load the interval counter
    logic waitAcq;  // 1: acquisition interval, 0: CS-high interval
  } seqCtl_t;

endpackage

// File: rtl/adc_cal_dp.sv
`timescale 1ns/1ps
module adc_cal_dp
  import adc_cal_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DATA_BITS   = 12,
  parameter int LEAD_BITS   = 2,
  parameter int CAL_EDGES   = 16,
  parameter int CS_HIGH_CYC = 10,
  parameter int ACQ_CYC     = 16,
  parameter int CAL_HALF_HI = 2,
  parameter int CAL_HALF_LO = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  seqCtl_t              ctl,
  input  logic [DIV_W-1:0]     sclkDiv,
  input  logic                 lowSupply,
  input  logic                 sdo,
  output logic                 sclk,
  output logic                 frameEnd,
  output logic                 riseOne,
  output logic                 waitDone,
  output logic [DATA_BITS-1:0] word
);

  localparam int SMP_EDGES = LEAD_BITS + DATA_BITS;
  localparam int MAX_EDGES = (CAL_EDGES > SMP_EDGES) ? CAL_EDGES : SMP_EDGES;
  localparam int EDGE_W    = $clog2(MAX_EDGES + 1);
  localparam int WAIT_MAX  = (CS_HIGH_CYC > ACQ_CYC) ? CS_HIGH_CYC : ACQ_CYC;
  localparam int WAIT_W    = $clog2(WAIT_MAX + 1);

  logic [DIV_W-1:0]     divBase, calFloor, halfEff, halfCnt;
  logic [EDGE_W-1:0]    edgeCnt, edgeTarget;
  logic [WAIT_W-1:0]    waitCnt;
  logic [DATA_BITS-1:0] shiftReg;
  logic                 tick;

  always_comb begin
    divBase    = (sclkDiv == '0) ? DIV_W'(1) : sclkDiv;
    calFloor   = lowSupply ? DIV_W'(CAL_HALF_LO) : DIV_W'(CAL_HALF_HI);
    halfEff    = (ctl.calMode && (divBase < calFloor)) ? calFloor : divBase;
    edgeTarget = ctl.calMode ? EDGE_W'(CAL_EDGES) : EDGE_W'(SMP_EDGES);
    tick       = ctl.run && (halfCnt == halfEff - DIV_W'(1));
    frameEnd   = tick && sclk && (edgeCnt == edgeTarget);
    riseOne    = tick && !sclk && sdo;
    waitDone   = (waitCnt == '0);
  end

  // Serial clock generator and rising-edge counter
  always_ff @(posedge clk) begin
    if (rst || !ctl.run || ctl.stop) begin
      sclk    <= 1'b0;
      halfCnt <= '0;
      edgeCnt <= '0;
    end else if (tick) begin
      halfCnt <= '0;
      sclk    <= !sclk;
      if (!sclk) edgeCnt <= edgeCnt + EDGE_W'(1);
    end else begin
      halfCnt <= halfCnt + DIV_W'(1);
    end
  end

  // Capture on the edge where sclk goes high
  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else if (tick && !sclk) shiftReg <= {shiftReg[DATA_BITS-2:0], sdo};
  end

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else if (frameEnd && !ctl.calMode) word <= shiftReg;
  end

  // Interval counter for CS-high and acquisition waits
  always_ff @(posedge clk) begin
    if (rst) waitCnt <= '0;
    else if (ctl.waitLoad)
      waitCnt <= ctl.waitAcq ? WAIT_W'(ACQ_CYC - 1) : WAIT_W'(CS_HIGH_CYC - 1);
    else if (waitCnt != '0) waitCnt <= waitCnt - WAIT_W'(1);
  end

endmodule

// File: rtl/adc_cal_ctrl.sv
`timescale 1ns/1ps
module adc_cal_ctrl
  import adc_cal_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    abortReq,
  input  logic    frameEnd,
  input  logic    riseOne,
  input  logic    waitDone,
  output seqCtl_t ctl,
  output logic    csN,
  output logic    calDone,
  output logic    calError,
  output logic    calNotApplied,
  output logic    sampleValid
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE:     if (start) nextState = ST_CAL_FALL;
      ST_CAL_FALL: nextState = ST_CAL_CLK;
      ST_CAL_CLK: begin
        ctl.run     = 1'b1;
        ctl.calMode = 1'b1;
        if (frameEnd || abortReq) begin
          nextState    = ST_CAL_HIGH;
          ctl.stop     = 1'b1;
          ctl.waitLoad = 1'b1;
        end
      end
      ST_CAL_HIGH: if (waitDone) begin
        nextState    = ST_ACQ_WAIT;
        ctl.waitLoad = 1'b1;
        ctl.waitAcq  = 1'b1;
      end
      ST_ACQ_WAIT: if (waitDone) nextState = ST_SAMPLE;
      ST_SAMPLE: begin
        ctl.run = 1'b1;
        if (frameEnd) begin
          nextState    = ST_SMP_HIGH;
          ctl.stop     = 1'b1;
          ctl.waitLoad = 1'b1;
        end
      end
      ST_SMP_HIGH: if (waitDone) nextState = ST_DONE;
      ST_DONE:     if (start) nextState = ST_SAMPLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  assign csN = !((state == ST_CAL_FALL) || (state == ST_CAL_CLK) || (state == ST_SAMPLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      calDone       <= 1'b0;
      calError      <= 1'b0;
      calNotApplied <= 1'b0;
      sampleValid   <= 1'b0;
    end else begin
      state       <= nextState;
      sampleValid <= (state == ST_SAMPLE) && frameEnd;
      if (state == ST_CAL_CLK) begin
        if (frameEnd)      calDone       <= 1'b1;
        else if (abortReq) calNotApplied <= 1'b1;
        if (riseOne)       calError      <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_cal_sequencer.sv
`timescale 1ns/1ps
module adc_cal_sequencer
  import adc_cal_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DATA_BITS   = 12,
  parameter int LEAD_BITS   = 2,
  parameter int CAL_EDGES   = 16,
  parameter int CS_HIGH_CYC = 10,
  parameter int ACQ_CYC     = 16,
  parameter int CAL_HALF_HI = 2,
  parameter int CAL_HALF_LO = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 abortReq,
  input  logic [DIV_W-1:0]     sclkDiv,
  input  logic                 lowSupply,
  input  logic                 sdo,
  output logic                 csN,
  output logic                 sclk,
  output logic                 calDone,
  output logic                 calError,
  output logic                 calNotApplied,
  output logic                 sampleValid,
  output logic [DATA_BITS-1:0] sampleData
);

  seqCtl_t ctl;
  logic    frameEnd, riseOne, waitDone;

  adc_cal_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .abortReq(abortReq),
    .frameEnd(frameEnd), .riseOne(riseOne), .waitDone(waitDone),
    .ctl(ctl), .csN(csN), .calDone(calDone), .calError(calError),
    .calNotApplied(calNotApplied), .sampleValid(sampleValid)
  );

  adc_cal_dp #(
    .DIV_W(DIV_W), .DATA_BITS(DATA_BITS), .LEAD_BITS(LEAD_BITS),
    .CAL_EDGES(CAL_EDGES), .CS_HIGH_CYC(CS_HIGH_CYC), .ACQ_CYC(ACQ_CYC),
    .CAL_HALF_HI(CAL_HALF_HI), .CAL_HALF_LO(CAL_HALF_LO)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .sclkDiv(sclkDiv), .lowSupply(lowSupply),
    .sdo(sdo), .sclk(sclk), .frameEnd(frameEnd), .riseOne(riseOne),
    .waitDone(waitDone), .word(sampleData)
  );

endmodule

// File: rtl/adc_cal_checker.sv
`timescale 1ns/1ps
module adc_cal_checker (
  input logic clk,
  input logic rst,
  input logic csN,
  input logic sclk,
  input logic calDone,
  input logic calError,
  input logic calNotApplied,
  input logic sampleValid
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (csN && !sclk && !calDone && !calError && !calNotApplied && !sampleValid));

  a_r2_done_sticky: assert property (@(posedge clk) disable iff (rst)
    calDone |=> calDone);

  a_r3_sclk_parked: assert property (@(posedge clk) disable iff (rst)
    csN |-> !sclk);

  a_r5_error_sticky: assert property (@(posedge clk) disable iff (rst)
    calError |=> calError);

  a_r6_abort_excludes_done: assert property (@(posedge clk) disable iff (rst)
    calNotApplied |-> !calDone);

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  a_r8_valid_outside_frame: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> csN);

endmodule

bind adc_cal_sequencer adc_cal_checker u_chk (
  .clk(clk), .rst(rst), .csN(csN), .sclk(sclk), .calDone(calDone),
  .calError(calError), .calNotApplied(calNotApplied), .sampleValid(sampleValid)
);

// File: tb/adc_cal_sequencer_bench.sv
`timescale 1ns/1ps
module adc_cal_sequencer_bench;

  localparam int CS_HIGH_CYC = 10;
  localparam int ACQ_CYC     = 16;
  localparam int NVEC        = 6;
  // {lowSupply, sclkDiv, sample word, calibration sdo mask (bit k-1 = edge k)}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 8'd1, 12'hA5C, 16'h0000},
    {1'b1, 8'd1, 12'h3C7, 16'h0000},
    {1'b1, 8'd0, 12'hFFF, 16'h0000},
    {1'b0, 8'd5, 12'h001, 16'h0000},
    {1'b1, 8'd2, 12'h800, 16'h0000},
    {1'b0, 8'd4, 12'h6B2, 16'h8000}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, abortReq = 1'b0;
  logic [7:0] sclkDiv = 8'd1;
  logic lowSupply = 1'b0, sdo = 1'b0;
  logic csN, sclk, calDone, calError, calNotApplied, sampleValid;
  logic [11:0] sampleData;

  adc_cal_sequencer #(.CS_HIGH_CYC(CS_HIGH_CYC), .ACQ_CYC(ACQ_CYC)) u_adc_cal_sequencer (
    .clk(clk), .rst(rst), .start(start), .abortReq(abortReq), .sclkDiv(sclkDiv),
    .lowSupply(lowSupply), .sdo(sdo), .csN(csN), .sclk(sclk), .calDone(calDone),
    .calError(calError), .calNotApplied(calNotApplied), .sampleValid(sampleValid),
    .sampleData(sampleData)
  );

  always #10 clk = !clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [11:0] curData = '0;
  logic [15:0] curMask = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Converter model and frame monitor, all at the falling clock edge
  bit monRst = 1;
  bit prevCs = 1, prevSclk = 0;
  int frameNo, rises, highRun, phaseLen, hiMin, hiMax, gapLast, sclkStray;
  int calRises, calHiMin, calHiMax, calGap, smpRises, smpHiMin, smpHiMax, smpGap;

  function automatic logic bitFor(input int frm, input int k);
    if (frm == 1) return (k >= 1 && k <= 16) ? curMask[k-1] : 1'b0;
    if (k == 1 || k == 2) return 1'b1;
    if (k >= 3 && k <= 14) return curData[14-k];
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (monRst) begin
      prevCs = 1; prevSclk = 0; frameNo = 0; rises = 0; highRun = 0; phaseLen = 0;
      hiMin = 999; hiMax = 0; gapLast = 0; sclkStray = 0; sdo = 0;
      calRises = 0; calHiMin = 0; calHiMax = 0; calGap = 0;
      smpRises = 0; smpHiMin = 0; smpHiMax = 0; smpGap = 0;
    end else begin
      if (prevCs && !csN) begin
        frameNo++; rises = 0; gapLast = highRun; highRun = 0; hiMin = 999; hiMax = 0;
        if (frameNo == 2) calGap = gapLast;
        if (frameNo >= 3) smpGap = gapLast;
        sdo = bitFor(frameNo, 1);
      end
      if (csN) highRun++;
      if (csN && prevCs && sclk != prevSclk) sclkStray++;
      if (prevSclk && !sclk) begin
        if (phaseLen < hiMin) hiMin = phaseLen;
        if (phaseLen > hiMax) hiMax = phaseLen;
      end
      if (!csN && sclk && !prevSclk) begin
        rises++; phaseLen = 1; sdo = bitFor(frameNo, rises + 1);
      end else if (sclk) phaseLen++;
      if (!prevCs && csN) begin
        if (frameNo == 1) begin calRises = rises; calHiMin = hiMin; calHiMax = hiMax; end
        else begin smpRises = rises; smpHiMin = hiMin; smpHiMax = hiMax; end
      end
      prevCs = csN; prevSclk = sclk;
    end
  end

  task automatic doReset();
    @(negedge clk); rst = 1; monRst = 1;
    repeat (3) @(negedge clk);
    rst = 0; monRst = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic waitValid(input string req, output logic [11:0] got);
    int n = 0;
    got = '0;
    while (!sampleValid && n < 3000) begin @(negedge clk); n++; end
    check(sampleValid == 1'b1, req, n, -1);
    got = sampleData;
    @(negedge clk);
    check(sampleValid == 1'b0, "R8 strobe one cycle", sampleValid, 0);
  endtask

  initial begin
    logic [11:0] got;
    // R1: reset state and no activity without start
    doReset();
    check(csN == 1'b1, "R1 csN after reset", csN, 1);
    check(sclk == 1'b0, "R1 sclk after reset", sclk, 0);
    check({calDone, calError, calNotApplied, sampleValid} == 4'b0, "R1 flags after reset",
          {calDone, calError, calNotApplied, sampleValid}, 0);
    repeat (40) @(negedge clk);
    check(frameNo == 0, "R1 no frame before start", frameNo, 0);

    // Vector table: full sequence for each divider / supply / data pattern
    for (int i = 0; i < NVEC; i++) begin
      int d, calHalf;
      {lowSupply, sclkDiv, curData, curMask} = VEC[i];
      d = (sclkDiv == 0) ? 1 : int'(sclkDiv);
      calHalf = lowSupply ? ((d < 3) ? 3 : d) : ((d < 2) ? 2 : d);
      doReset();
      pulseStart();
      waitValid("R7 first sample arrives", got);
      check(got == curData, "R8 sample word", got, curData);
      check(calRises == 16, "R2 calibration edges", calRises, 16);
      check(calDone == 1'b1, "R2 calDone", calDone, 1);
      check(calHiMin == calHalf && calHiMax == calHalf, "R4 cal half period", calHiMin, calHalf);
      check(smpRises == 14, "R8 sample edges", smpRises, 14);
      check(smpHiMin == d && smpHiMax == d, "R8 sample half period", smpHiMin, d);
      check(calGap >= CS_HIGH_CYC + ACQ_CYC, "R7 acquisition gap", calGap, CS_HIGH_CYC + ACQ_CYC);
      check(calError == (curMask != 0), "R5 cal error flag", calError, curMask != 0);
      check(calNotApplied == 1'b0, "R6 no abort flag", calNotApplied, 0);
      check(frameNo == 2, "R7 two frames", frameNo, 2);
    end

    // R6: abort after five calibration edges
    lowSupply = 0; sclkDiv = 8'd2; curData = 12'h5A5; curMask = '0;
    doReset();
    pulseStart();
    while (!(frameNo == 1 && rises == 5)) @(negedge clk);
    abortReq = 1;
    @(negedge clk); abortReq = 0;
    @(negedge clk);
    check(csN == 1'b1, "R6 abort ends frame", csN, 1);
    check(calRises == 5, "R6 aborted edge count", calRises, 5);
    check(calNotApplied == 1'b1, "R6 not-applied flag", calNotApplied, 1);
    check(calDone == 1'b0, "R6 calDone clear", calDone, 0);
    waitValid("R6 sequence continues", got);
    check(got == curData, "R6 sample after abort", got, curData);
    @(negedge clk); abortReq = 1;
    @(negedge clk); abortReq = 0;
    repeat (20) @(negedge clk);
    check(frameNo == 2 && csN == 1'b1, "R6 abort ignored when idle", frameNo, 2);
    check(calNotApplied == 1'b1 && calDone == 1'b0, "R6 flags unchanged", calNotApplied, 1);

    // R9: start during the post-frame wait is ignored; start in done runs a frame
    curData = 12'h9C3;
    doReset();
    pulseStart();
    waitValid("R9 first sample", got);
    pulseStart();
    repeat (30) @(negedge clk);
    check(frameNo == 2, "R9 start during wait ignored", frameNo, 2);
    pulseStart();
    repeat (3) @(negedge clk);
    pulseStart();
    waitValid("R9 second sample", got);
    check(got == curData, "R9 second sample word", got, curData);
    check(smpGap >= CS_HIGH_CYC, "R9 CS high between samples", smpGap, CS_HIGH_CYC);
    repeat (40) @(negedge clk);
    check(frameNo == 3, "R9 start in frame ignored", frameNo, 3);

    // R10: reset in the middle of a sample frame brings back calibration
    pulseStart();
    repeat (4) @(negedge clk);
    check(csN == 1'b0, "R10 frame in progress", csN, 0);
    doReset();
    check(csN == 1'b1 && calDone == 1'b0, "R10 reset mid-frame", calDone, 0);
    pulseStart();
    waitValid("R10 sequence restarts", got);
    check(calRises == 16 && calDone == 1'b1, "R10 calibration frame again", calRises, 16);
    check(sclkStray == 0, "R3 no sclk outside frame", sclkStray, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule